// File: doc/BRIEF.md
# Branch Target Buffer with Static Fallback Predictor

This block predicts direction and target for a fetch front end. A direct-mapped table of 64 entries is searched with the fetch PC. Each entry holds a valid bit, an upper-PC tag, a branch target and a 2-bit saturating counter. On a tag match the counter sets the direction and the stored target is used.

When the table misses, a fixed rule set takes over. It uses the branch kind and the displacement supplied by decode:

- PC-relative jumps are predicted taken.
- PC-relative conditional branches are predicted taken only when they point backwards.
- Returns are predicted taken to the address given on the return-target input.
- Indirect jumps raise a stall request, because only decode can supply their target.

Resolved branches train the table one cycle at a time. A matching entry has its counter stepped with saturation. A non-matching slot is overwritten with a fresh entry whose counter starts just on the side of the outcome.

Top module: `fetch_bpred`

## Requirements
- R1: After reset every entry is invalid, so every lookup follows the static rules (R4 to R7) until an entry is written.
- R2: On a hit, the prediction is taken when the counter is 2 or 3, with the stored target; it is not taken when the counter is 0 or 1, with target PC+4. On a hit the stall is 0 and the branch kind and displacement have no effect.
- R3: The index is PC[7:2] and the tag is PC[31:8]. A lookup whose tag differs from a valid entry at the same index is a miss.
- R4: On a miss with kind 2'b00 (PC-relative jump), the prediction is taken with target PC plus the sign-extended 16-bit displacement, and the stall is 0.
- R5: On a miss with kind 2'b01 (PC-relative conditional), a negative displacement (bit 15 set) predicts taken with target PC plus the sign-extended displacement. Otherwise the prediction is not taken with target PC+4. The stall is 0 in both cases.
- R6: On a miss with kind 2'b10 (return), the prediction is taken with the return-target input as the target, and the stall is 0.
- R7: On a miss with kind 2'b11 (indirect), the stall is 1, the prediction is not taken, and the target is PC+4.
- R8: A resolved branch that hits its entry increments the counter when taken and decrements it when not taken. A taken outcome replaces the stored target; a not-taken outcome keeps it. The change is visible to lookups from the cycle after the update.
- R9: A resolved branch that misses writes its slot with valid, its tag and its target, and with counter 2'b10 if taken or 2'b01 if not taken. This evicts any other tag held in that slot.
- R10: The counter saturates: a taken update at 3 stays 3, and a not-taken update at 0 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_pc | input | 32 | Fetch PC to predict |
| dec_kind | input | 2 | Branch kind: 00 relative jump, 01 relative conditional, 10 return, 11 indirect |
| dec_disp | input | 16 | Signed byte displacement of a relative branch |
| ret_target | input | 32 | Return address to use for a predicted return |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted next fetch address |
| fetch_stall | output | 1 | Hold fetch until decode supplies the target |

## Verification
All three prediction outputs are combinational in the lookup inputs and the current table contents. The bench therefore checks them in the same cycle, a short settle time after it drives a lookup and well away from the clock edge. A resolved-branch update is captured on the next rising edge. It is due at the outputs from that edge on, so every update is followed by a lookup sampled just after that edge, and the expected value comes from a bench-side model advanced at the same point.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        BK_JUMP_REL = 2'b00,
        BK_COND_REL = 2'b01,
        BK_RETURN   = 2'b10,
        BK_INDIRECT = 2'b11
    } br_kind_e;

    localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;
    localparam logic [1:0] CTR_WEAK_NOT   = 2'b01;

    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
        logic [1:0] nxt;
        nxt = cur;
        if (up && cur != 2'b11) begin
            nxt = cur + 2'b01;
        end else if (!up && cur != 2'b00) begin
            nxt = cur - 2'b01;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bpred_table.sv
module bpred_table
    import bpred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [1:0]       rd_ctr,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    input  logic [PC_W-1:0]  wr_target
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
        logic [1:0]       ctr;
    } entry_t;

    entry_t ent_q [DEPTH];
    entry_t ent_d [DEPTH];
    entry_t rd_ent;
    entry_t wr_ent;
    entry_t wr_new;
    logic   wr_hit;

    assign rd_ent    = ent_q[rd_idx];
    assign rd_hit    = rd_ent.valid && (rd_ent.tag == rd_tag);
    assign rd_ctr    = rd_ent.ctr;
    assign rd_target = rd_ent.target;

    always_comb begin
        wr_ent = ent_q[wr_idx];
        wr_hit = wr_ent.valid && (wr_ent.tag == wr_tag);
        wr_new = wr_ent;
        if (wr_hit) begin
            wr_new.ctr = ctr_step(wr_ent.ctr, wr_taken);
            if (wr_taken) begin
                wr_new.target = wr_target;
            end
        end else begin
            wr_new.valid  = 1'b1;
            wr_new.tag    = wr_tag;
            wr_new.target = wr_target;
            wr_new.ctr    = wr_taken ? CTR_WEAK_TAKEN : CTR_WEAK_NOT;
        end
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx] = wr_new;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assert_alloc_ctr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=>
        (ent_q[$past(wr_idx)].ctr == ($past(wr_taken) ? CTR_WEAK_TAKEN : CTR_WEAK_NOT)));

    assert_sat_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && wr_taken && wr_ent.ctr == 2'b11) |=>
        (ent_q[$past(wr_idx)].ctr == 2'b11));

    assert_sat_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && !wr_taken && wr_ent.ctr == 2'b00) |=>
        (ent_q[$past(wr_idx)].ctr == 2'b00));

    assert_step_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && wr_taken && wr_ent.ctr != 2'b11) |=>
        (ent_q[$past(wr_idx)].ctr == $past(wr_ent.ctr) + 2'b01));

endmodule

// File: rtl/bpred_static.sv
module bpred_static
    import bpred_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DISP_W = 16
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [PC_W-1:0]   fall_through,
    input  br_kind_e          kind,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   ret_target,
    output logic              s_taken,
    output logic [PC_W-1:0]   s_target,
    output logic              s_stall
);

    logic [PC_W-1:0] rel_target;
    logic            backward;

    assign rel_target = pc + {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
    assign backward   = disp[DISP_W-1];

    always_comb begin
        s_taken  = 1'b0;
        s_target = fall_through;
        s_stall  = 1'b0;
        unique case (kind)
            BK_JUMP_REL: begin
                s_taken  = 1'b1;
                s_target = rel_target;
            end
            BK_COND_REL: begin
                if (backward) begin
                    s_taken  = 1'b1;
                    s_target = rel_target;
                end
            end
            BK_RETURN: begin
                s_taken  = 1'b1;
                s_target = ret_target;
            end
            BK_INDIRECT: begin
                s_stall = 1'b1;
            end
            default: begin
                s_stall = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fetch_bpred.sv
module fetch_bpred
    import bpred_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 6,
    parameter int DISP_W  = 16,
    parameter int ALIGN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lookup_pc,
    input  logic [1:0]        dec_kind,
    input  logic [DISP_W-1:0] dec_disp,
    input  logic [PC_W-1:0]   ret_target,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [PC_W-1:0]   upd_target,
    output logic              pred_taken,
    output logic [PC_W-1:0]   pred_target,
    output logic              fetch_stall
);

    localparam int TAG_W = PC_W - IDX_W - ALIGN_W;
    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(1 << ALIGN_W);

    logic             tbl_hit;
    logic [1:0]       tbl_ctr;
    logic [PC_W-1:0]  tbl_target;
    logic [PC_W-1:0]  fall_through;
    logic             st_taken;
    logic [PC_W-1:0]  st_target;
    logic             st_stall;
    br_kind_e         kind;
    logic [ALIGN_W-1:0] unused_upd_low;

    assign unused_upd_low = upd_pc[ALIGN_W-1:0];
    assign fall_through   = lookup_pc + INSN_BYTES;
    assign kind           = br_kind_e'(dec_kind);

    bpred_table #(
        .PC_W (PC_W),
        .IDX_W(IDX_W),
        .TAG_W(TAG_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lookup_pc[ALIGN_W +: IDX_W]),
        .rd_tag   (lookup_pc[PC_W-1 -: TAG_W]),
        .rd_hit   (tbl_hit),
        .rd_ctr   (tbl_ctr),
        .rd_target(tbl_target),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[ALIGN_W +: IDX_W]),
        .wr_tag   (upd_pc[PC_W-1 -: TAG_W]),
        .wr_taken (upd_taken),
        .wr_target(upd_target)
    );

    bpred_static #(
        .PC_W  (PC_W),
        .DISP_W(DISP_W)
    ) u_static (
        .pc          (lookup_pc),
        .fall_through(fall_through),
        .kind        (kind),
        .disp        (dec_disp),
        .ret_target  (ret_target),
        .s_taken     (st_taken),
        .s_target    (st_target),
        .s_stall     (st_stall)
    );

    always_comb begin
        if (tbl_hit) begin
            pred_taken  = tbl_ctr[1];
            pred_target = tbl_ctr[1] ? tbl_target : fall_through;
            fetch_stall = 1'b0;
        end else begin
            pred_taken  = st_taken;
            pred_target = st_target;
            fetch_stall = st_stall;
        end
    end

    assert_hit_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_hit |-> !fetch_stall);

    assert_stall_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> (!pred_taken && pred_target == lookup_pc + INSN_BYTES));

    assert_backward_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tbl_hit && kind == BK_COND_REL && dec_disp[DISP_W-1]) |-> pred_taken);

    assert_jump_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tbl_hit && kind == BK_JUMP_REL) |-> (pred_taken && !fetch_stall));

endmodule

// File: tb/fetch_bpred_bench.sv
module fetch_bpred_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lookup_pc = '0;
    logic [1:0]  dec_kind = '0;
    logic [15:0] dec_disp = '0;
    logic [31:0] ret_target = 32'h0000_7000;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic        fetch_stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_v   [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];
    logic [1:0]  m_ctr [64];

    always #2.5 clk = ~clk;

    fetch_bpred u_fetch_bpred (
        .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .dec_kind(dec_kind),
        .dec_disp(dec_disp), .ret_target(ret_target), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
        .pred_taken(pred_taken), .pred_target(pred_target), .fetch_stall(fetch_stall)
    );

    task automatic model_update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        int i = int'(pc[7:2]);
        if (m_v[i] && m_tag[i] == pc[31:8]) begin
            if (tk && m_ctr[i] != 2'd3) m_ctr[i] = m_ctr[i] + 2'd1;
            if (!tk && m_ctr[i] != 2'd0) m_ctr[i] = m_ctr[i] - 2'd1;
            if (tk) m_tgt[i] = tg;
        end else begin
            m_v[i] = 1'b1; m_tag[i] = pc[31:8]; m_tgt[i] = tg;
            m_ctr[i] = tk ? 2'b10 : 2'b01;
        end
    endtask

    task automatic do_update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update(pc, tk, tg);
    endtask

    task automatic look(input string req, input logic [31:0] pc, input logic [1:0] kd,
                        input logic [15:0] dp);
        int i = int'(pc[7:2]);
        logic e_tk, e_st;
        logic [31:0] e_tg;
        logic [31:0] rel;
        lookup_pc = pc; dec_kind = kd; dec_disp = dp;
        #0.5;
        rel = pc + {{16{dp[15]}}, dp};
        e_st = 1'b0; e_tk = 1'b0; e_tg = pc + 32'd4;
        if (m_v[i] && m_tag[i] == pc[31:8]) begin
            e_tk = m_ctr[i][1];
            if (e_tk) e_tg = m_tgt[i];
        end else begin
            case (kd)
                2'b00: begin e_tk = 1'b1; e_tg = rel; end
                2'b01: if (dp[15]) begin e_tk = 1'b1; e_tg = rel; end
                2'b10: begin e_tk = 1'b1; e_tg = ret_target; end
                default: e_st = 1'b1;
            endcase
        end
        checks++;
        if (pred_taken !== e_tk || pred_target !== e_tg || fetch_stall !== e_st) begin
            errors++;
            $display("FAIL %s pc=%h kind=%0d disp=%h: taken/target/stall = %b/%h/%b expected %b/%h/%b",
                     req, pc, kd, dp, pred_taken, pred_target, fetch_stall, e_tk, e_tg, e_st);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] disps [5];
        disps[0] = 16'h0010; disps[1] = 16'hFFF0; disps[2] = 16'h7FFC;
        disps[3] = 16'h8000; disps[4] = 16'h0000;
        for (int i = 0; i < 64; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: after reset all slots miss, static rules apply
        for (int i = 0; i < 64; i++) begin
            look("R1", {24'h00A5C3, i[5:0], 2'b00}, 2'b01, 16'h0040);
            look("R1", {24'h00A5C3, i[5:0], 2'b00}, 2'b00, 16'hFF00);
        end

        // R4..R7: static sweep on misses
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < 5; d++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [31:0] pc = 32'h1000_0000 + 32'(p * 32'h0001_0104);
                    case (k)
                        0: look("R4", pc, 2'(k), disps[d]);
                        1: look("R5", pc, 2'(k), disps[d]);
                        2: look("R6", pc, 2'(k), disps[d]);
                        default: look("R7", pc, 2'(k), disps[d]);
                    endcase
                end
            end
        end

        // R9: allocate every slot, alternate outcome; R2: hit overrides kind
        for (int i = 0; i < 64; i++) begin
            logic [31:0] pc = {24'h000200 + 24'(i * 7), i[5:0], 2'b00};
            do_update(pc, i[0], 32'h4000_0000 + 32'(i * 16));
        end
        for (int i = 0; i < 64; i++) begin
            logic [31:0] pc = {24'h000200 + 24'(i * 7), i[5:0], 2'b00};
            look("R9", pc, 2'b11, 16'h8000);
            look("R2", pc, 2'(i % 4), 16'hFFF0);
        end

        // R3: same index, different tag misses
        for (int i = 0; i < 64; i += 9) begin
            logic [31:0] pc = {24'h00F000 + 24'(i), i[5:0], 2'b00};
            look("R3", pc, 2'b11, 16'h0000);
            look("R3", pc, 2'b01, 16'h0020);
        end

        // R8 / R10: counter walk on one slot with target changes
        begin
            logic [31:0] pc = 32'h0ABC_D014;
            do_update(pc, 1'b0, 32'h0000_1111);
            look("R9", pc, 2'b00, 16'h0100);
            for (int s = 0; s < 5; s++) begin
                do_update(pc, 1'b1, 32'h0000_2000 + 32'(s));
                look("R8", pc, 2'b11, 16'h0000);
            end
            look("R10", pc, 2'b01, 16'h0010);
            for (int s = 0; s < 5; s++) begin
                do_update(pc, 1'b0, 32'h0000_3000 + 32'(s));
                look("R8", pc, 2'b11, 16'h0000);
            end
            look("R10", pc, 2'b00, 16'h0010);
            do_update(pc, 1'b1, 32'h0000_5555);
            look("R10", pc, 2'b11, 16'h0000);
            do_update(pc, 1'b1, 32'h0000_6666);
            look("R8", pc, 2'b11, 16'h0000);
            do_update(pc, 1'b0, 32'h0000_7777);
            do_update(pc, 1'b1, 32'h0000_8888);
            look("R8", pc, 2'b10, 16'h0000);
        end

        // R9: eviction by a conflicting tag
        begin
            logic [31:0] a = 32'h0000_1028;
            logic [31:0] b = 32'h0077_7028;
            do_update(a, 1'b1, 32'h0000_AAAA);
            look("R9", a, 2'b11, 16'h0000);
            look("R3", b, 2'b11, 16'h0000);
            do_update(b, 1'b0, 32'h0000_BBBB);
            look("R9", b, 2'b10, 16'h0000);
            look("R9", a, 2'b01, 16'hFFFC);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule